// File: doc/BRIEF.md
# CAN Bus Error Capture and Error Counter Unit

This block sits beside a CAN protocol engine and keeps the diagnostic record software needs after a bus fault. When the engine reports a bus error, the block latches the kind of error, whether the node was sending or receiving, and a 5-bit code for the part of the frame in which the error was seen. When the engine reports lost arbitration, it latches the bit index at which that happened. Both records are shown in one status word. Each record stays frozen until software reads the status word, so the first fault after a read is the one that gets reported.

The block also holds the transmit and receive error counters. The engine drives them with increment and decrement pulses. Each counter saturates at both ends. Writing zero to the error-count word clears both counters and the captured error code. Each capture also produces a one-cycle event pulse for the interrupt logic.

Top module: `can_err_capture`

## Requirements
- R1: After reset, `status_word`, `err_count`, `berr_evt` and `arb_evt` are all zero.
- R2: A `berr_valid` cycle while the error record is unlocked loads, from the next cycle on, the kind into status bits 23:22 (0 bit, 1 form, 2 stuff, 3 other), the direction into bit 21 (0 transmitting, 1 receiving) and the frame segment code into bits 20:16. The segment code is stored as given, for example 0x03 start of frame, 0x0A data field, 0x19 ACK slot, 0x1C overload.
- R3: Once captured, the error fields do not change on later `berr_valid` cycles until a `status_rd` cycle. A read cycle unlocks the record and keeps the fields. A `berr_valid` cycle in the same cycle as the read is captured.
- R4: A captured `arb_valid` puts `arb_bit` in status bits 12:8 under the same capture-and-hold-until-read rule. This lock is independent of the error-record lock.
- R5: `berr_evt` (`arb_evt`) is high for exactly the one cycle after each capture of an error (arbitration) record. It stays low for reports that are dropped because the record is locked.
- R6: The transmit counter is in `err_count` bits 7:0 and the receive counter in bits 23:16. An increment pulse adds 8 when `inc_big` is 1 and 1 otherwise. A decrement pulse subtracts 1. When a counter gets both pulses in one cycle, the increment applies and the decrement is ignored.
- R7: A counter at 255 stays at 255 on increments, and a counter at 0 stays at 0 on decrements.
- R8: A `cnt_wr` cycle with `cnt_wdata` equal to zero clears both counters, the error fields of the status word and the error-record lock. It leaves the arbitration field unchanged. It wins over a capture or a counter pulse in the same cycle.
- R9: A `cnt_wr` cycle with nonzero data changes neither `err_count` nor `status_word`.
- R10: Status bits 31:24, 15:13 and 7:0 and count bits 31:24 and 15:8 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| berr_valid | input | 1 | Bus error reported this cycle |
| berr_kind | input | 2 | Error kind: 0 bit, 1 form, 2 stuff, 3 other |
| berr_rx | input | 1 | 1 if the error was seen while receiving |
| berr_seg | input | 5 | Frame segment code of the error |
| arb_valid | input | 1 | Arbitration lost this cycle |
| arb_bit | input | 5 | Bit index at which arbitration was lost |
| status_rd | input | 1 | Software read of the status word (unlocks both records) |
| tx_inc | input | 1 | Transmit counter increment pulse |
| tx_dec | input | 1 | Transmit counter decrement pulse |
| rx_inc | input | 1 | Receive counter increment pulse |
| rx_dec | input | 1 | Receive counter decrement pulse |
| inc_big | input | 1 | Increment step is 8 instead of 1 |
| cnt_wr | input | 1 | Software write to the error-count word |
| cnt_wdata | input | 32 | Write data for the error-count word |
| status_word | output | 32 | Captured error code and arbitration-lost index |
| err_count | output | 32 | Transmit and receive error counters |
| berr_evt | output | 1 | One-cycle pulse on each error capture |
| arb_evt | output | 1 | One-cycle pulse on each arbitration capture |

## Verification
Eight capture patterns are run, each preceded by a read. They cover every error kind, both directions, segment codes from several frame regions and arbitration indices up to 31. Between them they tell apart swapped or shifted fields, and the all-ones pattern shows whether any field spills into the zero bits. Directed cases then separate a dropped report from a captured one. They cover a locked record, a read together with a new report, a read alone, and an arbitration capture without an error. Counter cases distinguish the two step sizes, increment priority, saturation at both ends, a nonzero write from a zero write, and a clear that coincides with a new error.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
    localparam int KIND_W      = 2;
    localparam int SEG_W       = 5;
    localparam int ARB_W       = 5;
    localparam int CODE_W      = KIND_W + 1 + SEG_W;
    localparam int ST_ARB_LSB  = 8;
    localparam int ST_CODE_LSB = 16;
    localparam int CNT_RX_LSB  = 16;
    localparam int WORD_W      = 32;

    typedef enum logic [KIND_W-1:0] {
        KIND_BIT   = 2'd0,
        KIND_FORM  = 2'd1,
        KIND_STUFF = 2'd2,
        KIND_OTHER = 2'd3
    } err_kind_e;

    // frame position codes as delivered by the protocol engine
    typedef enum logic [SEG_W-1:0] {
        SEG_ID_HI      = 5'h02,
        SEG_SOF        = 5'h03,
        SEG_SUBST_RTR  = 5'h04,
        SEG_ID_EXT     = 5'h05,
        SEG_ID_MID     = 5'h06,
        SEG_ID_EXT_HI  = 5'h07,
        SEG_CRC        = 5'h08,
        SEG_RSV0       = 5'h09,
        SEG_DATA       = 5'h0A,
        SEG_LEN        = 5'h0B,
        SEG_RTR        = 5'h0C,
        SEG_RSV1       = 5'h0D,
        SEG_ID_EXT_LO  = 5'h0E,
        SEG_ID_EXT_MID = 5'h0F,
        SEG_ACT_FLAG   = 5'h11,
        SEG_IFS        = 5'h12,
        SEG_TOL_DOM    = 5'h13,
        SEG_PAS_FLAG   = 5'h16,
        SEG_ERR_DELIM  = 5'h17,
        SEG_CRC_DELIM  = 5'h18,
        SEG_ACK        = 5'h19,
        SEG_EOF        = 5'h1A,
        SEG_ACK_DELIM  = 5'h1B,
        SEG_OVERLOAD   = 5'h1C
    } seg_code_e;
endpackage

// File: rtl/errcap_hold.sv
module errcap_hold #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_i,
    input  logic [W-1:0] data_i,
    input  logic         rel_i,
    input  logic         clr_i,
    output logic [W-1:0] data_o,
    output logic         held_o,
    output logic         evt_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic         held;
        logic         evt;
    } hold_s;

    hold_s st_d, st_q;
    logic  take;

    always_comb begin
        st_d = st_q;
        take = cap_i && (!st_q.held || rel_i);
        if (clr_i) begin
            st_d.data = '0;
            st_d.held = 1'b0;
            st_d.evt  = 1'b0;
        end else begin
            st_d.evt = take;
            if (take) begin
                st_d.data = data_i;
                st_d.held = 1'b1;
            end else if (rel_i) begin
                st_d.held = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o = st_q.data;
    assign held_o = st_q.held;
    assign evt_o  = st_q.evt;
endmodule

// File: rtl/errcap_counter.sv
module errcap_counter #(
    parameter int CNT_W    = 8,
    parameter int BIG_STEP = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             big_i,
    input  logic             dec_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W:0] MAX_V  = {1'b0, {CNT_W{1'b1}}};
    localparam logic [CNT_W:0] STEP_B = (CNT_W+1)'(BIG_STEP);
    localparam logic [CNT_W:0] STEP_S = (CNT_W+1)'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s           st_d, st_q;
    logic [CNT_W:0] sum;

    always_comb begin
        st_d = st_q;
        sum  = {1'b0, st_q.cnt} + (big_i ? STEP_B : STEP_S);
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (inc_i) begin
            st_d.cnt = (sum > MAX_V) ? MAX_V[CNT_W-1:0] : sum[CNT_W-1:0];
        end else if (dec_i && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;
endmodule

// File: rtl/can_err_capture.sv
module can_err_capture
    import errcap_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int BIG_STEP = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        berr_valid,
    input  logic [1:0]  berr_kind,
    input  logic        berr_rx,
    input  logic [4:0]  berr_seg,
    input  logic        arb_valid,
    input  logic [4:0]  arb_bit,
    input  logic        status_rd,
    input  logic        tx_inc,
    input  logic        tx_dec,
    input  logic        rx_inc,
    input  logic        rx_dec,
    input  logic        inc_big,
    input  logic        cnt_wr,
    input  logic [31:0] cnt_wdata,
    output logic [31:0] status_word,
    output logic [31:0] err_count,
    output logic        berr_evt,
    output logic        arb_evt
);
    localparam int NCNT = 2;

    logic              clear;
    logic [CODE_W-1:0] code_in, code_q;
    logic [ARB_W-1:0]  arb_q;
    logic              err_held, arb_held;
    logic [NCNT-1:0]   c_inc, c_dec;
    logic [CNT_W-1:0]  c_val [NCNT];

    assign clear   = cnt_wr && (cnt_wdata == '0);
    assign code_in = {berr_kind, berr_rx, berr_seg};
    assign c_inc   = {rx_inc, tx_inc};
    assign c_dec   = {rx_dec, tx_dec};

    errcap_hold #(.W(CODE_W)) u_err_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (berr_valid),
        .data_i (code_in),
        .rel_i  (status_rd),
        .clr_i  (clear),
        .data_o (code_q),
        .held_o (err_held),
        .evt_o  (berr_evt)
    );

    errcap_hold #(.W(ARB_W)) u_arb_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (arb_valid),
        .data_i (arb_bit),
        .rel_i  (status_rd),
        .clr_i  (1'b0),
        .data_o (arb_q),
        .held_o (arb_held),
        .evt_o  (arb_evt)
    );

    // index 0 is the transmit counter, index 1 the receive counter
    for (genvar g = 0; g < NCNT; g++) begin : g_cnt
        errcap_counter #(.CNT_W(CNT_W), .BIG_STEP(BIG_STEP)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc_i (c_inc[g]),
            .big_i (inc_big),
            .dec_i (c_dec[g]),
            .clr_i (clear),
            .cnt_o (c_val[g])
        );
    end

    always_comb begin
        status_word = '0;
        status_word[ST_CODE_LSB +: CODE_W] = code_q;
        status_word[ST_ARB_LSB  +: ARB_W]  = arb_q;
        err_count = '0;
        err_count[0          +: CNT_W] = c_val[0];
        err_count[CNT_RX_LSB +: CNT_W] = c_val[1];
    end
endmodule

// File: rtl/errcap_checker.sv
module errcap_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        berr_valid,
    input logic        status_rd,
    input logic        tx_inc,
    input logic        tx_dec,
    input logic        cnt_wr,
    input logic [31:0] cnt_wdata,
    input logic [31:0] status_word,
    input logic [31:0] err_count,
    input logic        berr_evt,
    input logic        err_held,
    input logic        arb_held
);
    logic clr;
    assign clr = cnt_wr && (cnt_wdata == 32'd0);

    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        err_held && !status_rd && !clr |=> $stable(status_word[23:16])); // R3

    AST_ARB_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        arb_held && !status_rd |=> $stable(status_word[12:8])); // R4

    AST_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        berr_evt |-> $past(berr_valid) && !$past(clr)); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (err_count == 32'd0) && (status_word[23:16] == 8'd0)); // R8

    AST_TX_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (err_count[7:0] == 8'hFF) && !clr && !(tx_dec && !tx_inc)
        |=> err_count[7:0] == 8'hFF); // R7
endmodule

bind can_err_capture errcap_checker u_errcap_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .berr_valid  (berr_valid),
    .status_rd   (status_rd),
    .tx_inc      (tx_inc),
    .tx_dec      (tx_dec),
    .cnt_wr      (cnt_wr),
    .cnt_wdata   (cnt_wdata),
    .status_word (status_word),
    .err_count   (err_count),
    .berr_evt    (berr_evt),
    .err_held    (err_held),
    .arb_held    (arb_held)
);

// File: tb/test_can_err_capture.sv
module test_can_err_capture;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        berr_valid = 0, berr_rx = 0, arb_valid = 0, status_rd = 0;
    logic [1:0]  berr_kind = 0;
    logic [4:0]  berr_seg = 0, arb_bit = 0;
    logic        tx_inc = 0, tx_dec = 0, rx_inc = 0, rx_dec = 0, inc_big = 0, cnt_wr = 0;
    logic [31:0] cnt_wdata = 0;
    logic [31:0] status_word, err_count;
    logic        berr_evt, arb_evt;
    int          n_chk = 0;
    int          n_err = 0;

    always #4 clk = ~clk;

    can_err_capture i_can_err_capture (
        .clk(clk), .rst_n(rst_n), .berr_valid(berr_valid), .berr_kind(berr_kind),
        .berr_rx(berr_rx), .berr_seg(berr_seg), .arb_valid(arb_valid), .arb_bit(arb_bit),
        .status_rd(status_rd), .tx_inc(tx_inc), .tx_dec(tx_dec), .rx_inc(rx_inc),
        .rx_dec(rx_dec), .inc_big(inc_big), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .status_word(status_word), .err_count(err_count), .berr_evt(berr_evt), .arb_evt(arb_evt)
    );

    // {kind[1:0], rx, seg[4:0], arb[4:0]}
    localparam logic [12:0] VEC [8] = '{
        {2'd0, 1'b0, 5'h03, 5'd0},
        {2'd1, 1'b1, 5'h02, 5'd1},
        {2'd2, 1'b0, 5'h0F, 5'd10},
        {2'd3, 1'b1, 5'h0A, 5'd20},
        {2'd0, 1'b1, 5'h08, 5'd5},
        {2'd1, 1'b0, 5'h19, 5'd11},
        {2'd2, 1'b1, 5'h1C, 5'd30},
        {2'd3, 1'b1, 5'h1F, 5'd31}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        berr_valid = 0; arb_valid = 0; status_rd = 0;
        tx_inc = 0; tx_dec = 0; rx_inc = 0; rx_dec = 0; inc_big = 0;
        cnt_wr = 0; cnt_wdata = 0;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic berr(input logic [1:0] k, input logic rx, input logic [4:0] s);
        berr_valid = 1; berr_kind = k; berr_rx = rx; berr_seg = s;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 status", status_word, 32'h0);
        chk("R1 count", err_count, 32'h0);
        chk("R1 events", {30'd0, berr_evt, arb_evt}, 32'h0);
        rst_n = 1;
        tick();

        // R2 R4 R5 R10 table of capture patterns
        for (int i = 0; i < 8; i++) begin
            status_rd = 1; tick(); idle();
            berr(VEC[i][12:11], VEC[i][10], VEC[i][9:5]);
            arb_valid = 1; arb_bit = VEC[i][4:0];
            tick(); idle();
            chk("R2 R4 R10 status", status_word, {8'h00, VEC[i][12:5], 3'b000, VEC[i][4:0], 8'h00});
            chk("R5 pulses", {30'd0, berr_evt, arb_evt}, 32'h3);
            tick();
            chk("R5 single cycle", {30'd0, berr_evt, arb_evt}, 32'h0);
        end

        // R3 locked record drops new reports
        berr(2'd0, 1'b0, 5'h12); arb_valid = 1; arb_bit = 5'd2;
        tick(); idle();
        chk("R3 R4 locked", status_word, 32'h00FF1F00);
        chk("R5 no pulse when dropped", {30'd0, berr_evt, arb_evt}, 32'h0);

        // R3 read together with a new report captures it
        status_rd = 1; berr(2'd1, 1'b0, 5'h16); arb_valid = 1; arb_bit = 5'd7;
        tick(); idle();
        chk("R3 read+capture", status_word, 32'h00560700);
        chk("R5 pulse on read+capture", {31'd0, berr_evt}, 32'h1);

        // R3 read alone keeps fields and unlocks
        status_rd = 1; tick(); idle();
        chk("R3 read keeps", status_word, 32'h00560700);
        berr(2'd2, 1'b1, 5'h11); tick(); idle();
        chk("R3 capture after read", status_word, 32'h00B10700);

        // R4 arbitration capture alone
        arb_valid = 1; arb_bit = 5'd9; tick(); idle();
        chk("R4 arb alone", status_word, 32'h00B10900);
        chk("R5 arb pulse only", {30'd0, berr_evt, arb_evt}, 32'h1);

        // R6 counters
        for (int i = 0; i < 3; i++) begin tx_inc = 1; tick(); idle(); end
        chk("R6 tx +1", err_count, 32'h00000003);
        tx_inc = 1; inc_big = 1; tick(); idle();
        chk("R6 tx +8", err_count, 32'h0000000B);
        tx_dec = 1; tick(); idle();
        chk("R6 tx -1", err_count, 32'h0000000A);
        tx_inc = 1; tx_dec = 1; tick(); idle();
        chk("R6 inc wins", err_count, 32'h0000000B);
        rx_inc = 1; inc_big = 1; tick(); idle();
        rx_dec = 1; tick(); idle();
        chk("R6 rx field", err_count, 32'h0007000B);

        // R7 saturation
        for (int i = 0; i < 40; i++) begin tx_inc = 1; inc_big = 1; tick(); end
        idle();
        chk("R7 tx top", err_count, 32'h000700FF);
        for (int i = 0; i < 10; i++) begin rx_dec = 1; tick(); end
        idle();
        chk("R7 rx bottom", err_count, 32'h000000FF);

        // R9 nonzero write ignored
        cnt_wr = 1; cnt_wdata = 32'h00010001; tick(); idle();
        chk("R9 count kept", err_count, 32'h000000FF);
        chk("R9 status kept", status_word, 32'h00B10900);

        // R8 zero write wins over a same-cycle capture and counter pulse
        cnt_wr = 1; cnt_wdata = 32'h0; berr(2'd3, 1'b1, 5'h1F); rx_inc = 1;
        tick(); idle();
        chk("R8 count cleared", err_count, 32'h0);
        chk("R8 code cleared arb kept", status_word, 32'h00000900);
        chk("R8 no pulse", {31'd0, berr_evt}, 32'h0);
        berr(2'd0, 1'b1, 5'h13); tick(); idle();
        chk("R8 lock released", status_word, 32'h00330900);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule